// File: doc/BRIEF.md
# Host Interrupt Status and Enable Controller

This block sits inside a bridge between an on-chip memory-mapped fabric and a PCI Express link. It gathers two kinds of interrupt sources and decides when the host has to be told. The first kind is a set of level-sensitive request lines from local components. The second kind is a set of mailbox-write strobes, each raised when an external master writes a given mailbox. Both kinds appear in a single 32-bit status word, and a 32-bit enable word uses the same bit positions. A host interrupt is wanted whenever any status bit and its enable bit are both set.

Software reads the status word and services the sources. It then clears the mailbox bits by writing ones to them. A level bit clears only when the component that raised it drops its line. The combined request is turned into events on the link side. In message mode, each new request gives one message-trigger pulse. In legacy mode, the block gives a wire-interrupt assert pulse and later a matching deassert pulse. Legacy signalling obeys the interrupt-disable bit of the configuration command word.

Top module: `hostirq_ctrl`

## Requirements
- R1: After reset, the status word and the enable word both read zero, and no event output pulses until a source is enabled and active.
- R2: Status bits 15:0 show the local request lines as sampled at the previous clock edge. Writes to these bits have no effect.
- R3: A one on mailbox strobe i sets status bit 16+i, and the bit stays set after the strobe ends. If a strobe and a clearing write reach the same bit in the same cycle, the bit ends up set.
- R4: A write to the status word (offset 0x0) clears each of bits 23:16 where the written data holds a one. A zero in the written data leaves the bit unchanged.
- R5: The enable word sits at offset 0x4. Its bits 23:0 are read/write and its bits 31:24 always read zero. Status bits 31:24 read zero and ignore writes. Any other offset reads zero.
- R6: The combined request is the OR over all bits of (status AND enable). A pending source with its enable bit clear does not cause an event. Setting that enable bit later does cause one.
- R7: When msi_mode_i is 1, msi_req_o pulses for one cycle on the clock edge after each edge at which the combined request goes from 0 to 1. It does not pulse again while the request stays high.
- R8: When msi_mode_i is 0 and command bit 10 is clear, intx_assert_o pulses once when the combined request turns on. intx_deassert_o pulses once when the request turns off. The two pulses always alternate, starting with an assert.
- R9: In legacy mode, setting command bit 10 while a legacy interrupt is asserted produces a deassert pulse on the next edge. While the bit is set, no assert is produced. Clearing the bit while the request is still high produces an assert on the next edge.
- R10: At most one of the three event outputs is high in any cycle. In message mode neither legacy output pulses, and command bit 10 has no effect on msi_req_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lvl_irq_i | input | 16 | Level-sensitive request lines from local components |
| mbx_wr_i | input | 8 | One-cycle strobes, one per mailbox written by an external master |
| reg_addr_i | input | 4 | Register byte offset (0x0 status, 0x4 enable) |
| reg_wr_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i (combinational) |
| cfg_cmd_i | input | 16 | Configuration command word; bit 10 disables legacy interrupts |
| msi_mode_i | input | 1 | 1 selects message signalling, 0 selects legacy wire signalling |
| msi_req_o | output | 1 | One-cycle request to send an interrupt message |
| intx_assert_o | output | 1 | One-cycle request to send a legacy assert |
| intx_deassert_o | output | 1 | One-cycle request to send a legacy deassert |

## Verification
The assertions assume that all inputs are synchronous to clk, that mailbox strobes are single-cycle pulses, and that a register write lasts one cycle. They also assume that the mode and the command word change only between edges. The stimulus changes inputs only on the falling edge. It changes one input group at a time, and it switches signalling mode only while the combined request is low, so every event can be tied to the one change that caused it. The checks cover the corner cases where level bits and mailbox bits share the word. These include writes that must not touch level bits, a strobe and a clear landing in the same cycle, and toggling the disable bit while a request is held high.

// File: rtl/hostirq_pkg.sv
package hostirq_pkg;

  localparam int WORD_W           = 32;
  localparam int CMD_W            = 16;
  localparam int CMD_INTX_DIS_BIT = 10;

  // Next value of one sticky mailbox bit: a new strobe wins over a clear.
  function automatic logic sticky_next(input logic cur, input logic set_b, input logic clr_b);
    return set_b | (cur & ~clr_b);
  endfunction

  // Combined host request from the status and enable words.
  function automatic logic any_pending(input logic [WORD_W-1:0] stat,
                                       input logic [WORD_W-1:0] enab);
    return |(stat & enab);
  endfunction

endpackage

// File: rtl/hostirq_regs.sv
module hostirq_regs
  import hostirq_pkg::*;
#(
  parameter int N_LVL    = 16,
  parameter int N_MBX    = 8,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int ENAB_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LVL-1:0]  lvl_irq_i,
  input  logic [N_MBX-1:0]  mbx_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic [WORD_W-1:0] stat_o,
  output logic [WORD_W-1:0] enab_o,
  output logic              stat_wr_o
);

  localparam int N_SRC  = N_LVL + N_MBX;
  localparam int MBX_LO = N_LVL;

  logic [N_LVL-1:0] lvl_q;
  logic [N_MBX-1:0] mbx_q;
  logic [N_SRC-1:0] enab_q;
  logic             stat_sel;
  logic             enab_sel;
  logic             stat_wr;
  logic             enab_wr;
  logic             unused_wdata;

  assign stat_sel  = (reg_addr_i == ADDR_W'(STAT_OFS));
  assign enab_sel  = (reg_addr_i == ADDR_W'(ENAB_OFS));
  assign stat_wr   = reg_wr_i & stat_sel;
  assign enab_wr   = reg_wr_i & enab_sel;
  assign stat_wr_o = stat_wr;

  assign unused_wdata = ^reg_wdata_i[WORD_W-1:N_SRC];

  // Level sources: sampled once per cycle, never written by software.
  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl_irq_i;
  end

  // Mailbox sources: sticky, cleared by writing one.
  for (genvar i = 0; i < N_MBX; i++) begin : g_mbx
    always_ff @(posedge clk) begin
      if (!rst_n) mbx_q[i] <= 1'b0;
      else        mbx_q[i] <= sticky_next(mbx_q[i], mbx_wr_i[i],
                                          stat_wr & reg_wdata_i[MBX_LO+i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       enab_q <= '0;
    else if (enab_wr) enab_q <= reg_wdata_i[N_SRC-1:0];
  end

  always_comb begin
    stat_o = '0;
    stat_o[N_SRC-1:0] = {mbx_q, lvl_q};
    enab_o = '0;
    enab_o[N_SRC-1:0] = enab_q;
  end

  always_comb begin
    reg_rdata_o = '0;
    if (stat_sel)      reg_rdata_o = stat_o;
    else if (enab_sel) reg_rdata_o = enab_o;
  end

endmodule

// File: rtl/hostirq_event.sv
module hostirq_event (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic msi_mode_i,
  input  logic intx_dis_i,
  output logic msi_req_o,
  output logic intx_assert_o,
  output logic intx_deassert_o,
  output logic intx_on_o
);

  logic req_q;
  logic req_rise;
  logic intx_target;
  logic intx_on;

  assign req_rise    = req_i & ~req_q;
  // The legacy wire must be asserted exactly while this holds.
  assign intx_target = ~msi_mode_i & req_i & ~intx_dis_i;
  assign intx_on_o   = intx_on;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q           <= 1'b0;
      intx_on         <= 1'b0;
      msi_req_o       <= 1'b0;
      intx_assert_o   <= 1'b0;
      intx_deassert_o <= 1'b0;
    end else begin
      req_q           <= req_i;
      intx_on         <= intx_target;
      msi_req_o       <= msi_mode_i & req_rise;
      intx_assert_o   <= intx_target & ~intx_on;
      intx_deassert_o <= ~intx_target & intx_on;
    end
  end

endmodule

// File: rtl/hostirq_ctrl.sv
module hostirq_ctrl
  import hostirq_pkg::*;
#(
  parameter int N_LVL    = 16,
  parameter int N_MBX    = 8,
  parameter int ADDR_W   = 4,
  parameter int STAT_OFS = 0,
  parameter int ENAB_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_LVL-1:0]  lvl_irq_i,
  input  logic [N_MBX-1:0]  mbx_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  input  logic [CMD_W-1:0]  cfg_cmd_i,
  input  logic              msi_mode_i,
  output logic              msi_req_o,
  output logic              intx_assert_o,
  output logic              intx_deassert_o
);

  logic [WORD_W-1:0] stat_w;
  logic [WORD_W-1:0] enab_w;
  logic [N_LVL-1:0]  lvl_w;
  logic [N_MBX-1:0]  mbx_w;
  logic              stat_wr_w;
  logic              req_w;
  logic              intx_dis_w;
  logic              intx_on_w;
  logic              unused_cmd;

  assign intx_dis_w = cfg_cmd_i[CMD_INTX_DIS_BIT];
  assign unused_cmd = ^cfg_cmd_i;

  hostirq_regs #(
    .N_LVL(N_LVL), .N_MBX(N_MBX), .ADDR_W(ADDR_W),
    .STAT_OFS(STAT_OFS), .ENAB_OFS(ENAB_OFS)
  ) i_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .lvl_irq_i  (lvl_irq_i),
    .mbx_wr_i   (mbx_wr_i),
    .reg_addr_i (reg_addr_i),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .stat_o     (stat_w),
    .enab_o     (enab_w),
    .stat_wr_o  (stat_wr_w)
  );

  assign lvl_w = stat_w[N_LVL-1:0];
  assign mbx_w = stat_w[N_LVL+N_MBX-1:N_LVL];
  assign req_w = any_pending(stat_w, enab_w);

  hostirq_event i_event (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_i          (req_w),
    .msi_mode_i     (msi_mode_i),
    .intx_dis_i     (intx_dis_w),
    .msi_req_o      (msi_req_o),
    .intx_assert_o  (intx_assert_o),
    .intx_deassert_o(intx_deassert_o),
    .intx_on_o      (intx_on_w)
  );

endmodule

// File: rtl/hostirq_chk.sv
module hostirq_chk #(
  parameter int N_LVL = 16,
  parameter int N_MBX = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_LVL-1:0] lvl_irq_i,
  input logic [N_LVL-1:0] lvl_w,
  input logic [N_MBX-1:0] mbx_w,
  input logic             stat_wr_w,
  input logic             intx_dis_w,
  input logic             msi_mode_i,
  input logic             msi_req_o,
  input logic             intx_assert_o,
  input logic             intx_deassert_o
);

  logic line_up;

  always_ff @(posedge clk) begin
    if (!rst_n)               line_up <= 1'b0;
    else if (intx_assert_o)   line_up <= 1'b1;
    else if (intx_deassert_o) line_up <= 1'b0;
  end

  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (lvl_w == $past(lvl_irq_i))); // R2

  AST_MBX_ONLY_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(mbx_w) & ~mbx_w)) |-> $past(stat_wr_w)); // R4

  AST_MSI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |=> !msi_req_o); // R7

  AST_MSI_MODE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    msi_req_o |-> $past(msi_mode_i)); // R7

  AST_INTX_ALTERNATE_ON: assert property (@(posedge clk) disable iff (!rst_n)
    intx_assert_o |-> !line_up); // R8

  AST_INTX_ALTERNATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    intx_deassert_o |-> line_up); // R8

  AST_NO_ASSERT_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    intx_assert_o |-> !$past(intx_dis_w)); // R9

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({msi_req_o, intx_assert_o, intx_deassert_o})); // R10

  AST_NO_INTX_IN_MSI: assert property (@(posedge clk) disable iff (!rst_n)
    intx_assert_o |-> !$past(msi_mode_i)); // R10

endmodule

bind hostirq_ctrl hostirq_chk #(.N_LVL(N_LVL), .N_MBX(N_MBX)) i_hostirq_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .lvl_irq_i      (lvl_irq_i),
  .lvl_w          (lvl_w),
  .mbx_w          (mbx_w),
  .stat_wr_w      (stat_wr_w),
  .intx_dis_w     (intx_dis_w),
  .msi_mode_i     (msi_mode_i),
  .msi_req_o      (msi_req_o),
  .intx_assert_o  (intx_assert_o),
  .intx_deassert_o(intx_deassert_o)
);

// File: tb/test_hostirq_ctrl.sv
module test_hostirq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam logic [3:0] A_STAT = 4'h0;
  localparam logic [3:0] A_ENAB = 4'h4;
  localparam logic [2:0] EV_NONE = 3'b000;
  localparam logic [2:0] EV_MSI  = 3'b100;
  localparam logic [2:0] EV_AS   = 3'b010;
  localparam logic [2:0] EV_DE   = 3'b001;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] lvl_irq_i = '0;
  logic [7:0]  mbx_wr_i = '0;
  logic [3:0]  reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] cfg_cmd_i = '0;
  logic        msi_mode_i = 1'b0;
  logic        msi_req_o;
  logic        intx_assert_o;
  logic        intx_deassert_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  logic [2:0] q_kind[$];
  int         q_cyc[$];
  string      q_tag[$];

  hostirq_ctrl i_hostirq_ctrl (
    .clk(clk), .rst_n(rst_n), .lvl_irq_i(lvl_irq_i), .mbx_wr_i(mbx_wr_i),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .cfg_cmd_i(cfg_cmd_i), .msi_mode_i(msi_mode_i),
    .msi_req_o(msi_req_o), .intx_assert_o(intx_assert_o),
    .intx_deassert_o(intx_deassert_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard: expected event kind and the cycle it must be seen in.
  task automatic expect_ev(input logic [2:0] kind, input int dly, input string tag);
    if (kind != EV_NONE) begin
      q_kind.push_back(kind);
      q_cyc.push_back(cyc + dly);
      q_tag.push_back(tag);
    end
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [2:0] ev;
      ev = {msi_req_o, intx_assert_o, intx_deassert_o};
      if (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
        checks++;
        if (ev !== q_kind[0]) begin
          errors++;
          $display("FAIL %s: event at cycle %0d actual %b expected %b", q_tag[0], cyc, ev, q_kind[0]);
        end
        void'(q_kind.pop_front());
        void'(q_cyc.pop_front());
        void'(q_tag.pop_front());
      end else if (ev != EV_NONE) begin
        checks++;
        errors++;
        $display("FAIL R6/R7/R8/R9: unexpected event at cycle %0d actual %b expected %b", cyc, ev, EV_NONE);
      end
    end
  end

  task automatic set_lvl(input logic [15:0] v, input logic [2:0] kind, input string tag);
    @(negedge clk);
    lvl_irq_i = v;
    expect_ev(kind, 2, tag);
  endtask

  task automatic mbx_pulse(input logic [7:0] v, input logic [2:0] kind, input string tag);
    @(negedge clk);
    mbx_wr_i = v;
    expect_ev(kind, 2, tag);
    @(negedge clk);
    mbx_wr_i = '0;
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d,
                        input logic [2:0] kind, input string tag);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    expect_ev(kind, 2, tag);
    @(negedge clk);
    reg_wr_i = 1'b0;
  endtask

  task automatic set_cmd(input logic [15:0] v, input logic [2:0] kind, input string tag);
    @(negedge clk);
    cfg_cmd_i = v;
    expect_ev(kind, 1, tag);
  endtask

  task automatic rd_check(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    #1;
    checks++;
    if (reg_rdata_o !== exp) begin
      errors++;
      $display("FAIL %s: read 0x%0h actual 0x%08h expected 0x%08h", tag, a, reg_rdata_o, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    while (cyc < WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected below %0d", cyc, WATCHDOG);
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1: reset state
    rd_check(A_STAT, 32'h0, "R1");
    rd_check(A_ENAB, 32'h0, "R1");
    checks++;
    if ({msi_req_o, intx_assert_o, intx_deassert_o} !== 3'b000) begin
      errors++;
      $display("FAIL R1: events actual %b expected 000", {msi_req_o, intx_assert_o, intx_deassert_o});
    end

    // R5: enable upper byte reads zero
    reg_wr(A_ENAB, 32'hFF00_0008, EV_NONE, "R5");
    rd_check(A_ENAB, 32'h0000_0008, "R5");

    // R8: legacy assert on a level source
    set_lvl(16'h0008, EV_AS, "R8");
    idle(3);
    rd_check(A_STAT, 32'h0000_0008, "R2");
    // R2/R5: writes to level bits and upper byte are ignored
    reg_wr(A_STAT, 32'hFF00_FFFF, EV_NONE, "R2");
    rd_check(A_STAT, 32'h0000_0008, "R2");
    // R6: unenabled level source shows in status but adds no event
    set_lvl(16'h0028, EV_NONE, "R6");
    idle(3);
    rd_check(A_STAT, 32'h0000_0028, "R6");
    set_lvl(16'h0000, EV_DE, "R8");
    idle(3);

    // R3/R4: mailbox bit 18
    reg_wr(A_ENAB, 32'h0004_0000, EV_NONE, "R5");
    mbx_pulse(8'h04, EV_AS, "R3");
    idle(3);
    rd_check(A_STAT, 32'h0004_0000, "R3");
    reg_wr(A_STAT, 32'h0000_0000, EV_NONE, "R4");
    rd_check(A_STAT, 32'h0004_0000, "R4");
    reg_wr(A_STAT, 32'h0004_0000, EV_DE, "R4");
    idle(2);
    rd_check(A_STAT, 32'h0000_0000, "R4");

    // R3: strobe and clear in the same cycle, strobe wins
    @(negedge clk);
    mbx_wr_i = 8'h02; reg_addr_i = A_STAT; reg_wdata_i = 32'h0002_0000; reg_wr_i = 1'b1;
    @(negedge clk);
    mbx_wr_i = '0; reg_wr_i = 1'b0;
    rd_check(A_STAT, 32'h0002_0000, "R3");
    reg_wr(A_STAT, 32'h0002_0000, EV_NONE, "R4");
    rd_check(A_STAT, 32'h0000_0000, "R4");

    // R9: disable bit in legacy mode
    reg_wr(A_ENAB, 32'h0004_0008, EV_NONE, "R5");
    set_lvl(16'h0008, EV_AS, "R8");
    idle(3);
    set_cmd(16'h0400, EV_DE, "R9");
    idle(3);
    set_lvl(16'h0000, EV_NONE, "R9");
    idle(2);
    set_lvl(16'h0008, EV_NONE, "R9");
    idle(3);
    set_cmd(16'h0000, EV_AS, "R9");
    idle(3);
    set_lvl(16'h0000, EV_DE, "R8");
    idle(3);

    // R5: unmapped offset
    rd_check(4'h8, 32'h0, "R5");

    // R7: message mode
    @(negedge clk);
    msi_mode_i = 1'b1;
    idle(2);
    set_lvl(16'h0008, EV_MSI, "R7");
    idle(3);
    mbx_pulse(8'h04, EV_NONE, "R7");
    idle(3);
    set_lvl(16'h0000, EV_NONE, "R7");
    idle(3);
    reg_wr(A_STAT, 32'h0004_0000, EV_NONE, "R7");
    idle(3);
    // R10: disable bit does not affect messages
    set_cmd(16'h0400, EV_NONE, "R10");
    set_lvl(16'h0008, EV_MSI, "R10");
    idle(3);
    set_lvl(16'h0000, EV_NONE, "R10");
    set_cmd(16'h0000, EV_NONE, "R10");
    idle(3);
    // R6: enabling an already pending source raises the request
    set_lvl(16'h0020, EV_NONE, "R6");
    idle(3);
    reg_wr(A_ENAB, 32'h0000_0028, EV_MSI, "R6");
    idle(3);
    set_lvl(16'h0000, EV_NONE, "R6");
    idle(5);

    checks++;
    if (q_cyc.size() != 0) begin
      errors++;
      $display("FAIL R7/R8: missing events actual %0d pending expected 0", q_cyc.size());
    end
    finish_run();
  end

endmodule